// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous NRZ serial line into characters. It runs from a receive clock that is 1, 16, 32 or 64 times the bit rate. It frames characters of 5 to 8 data bits, an optional parity bit and one stop bit. For each character it hands the next stage the data, a parity error flag and a framing error flag, together with a one-cycle write strobe. That stage is normally a small receive FIFO.

A line held low for a whole character, with the stop bit missing as well, is treated as a break rather than as data. The block raises a break status bit and holds it for as long as the line stays low. When the line goes high again, the block writes a single null character.

An optional auto-enable mode lets an active-low carrier-detect pin switch the receiver on and off. The synchronised carrier state is always available as a status output. Both the serial line and the carrier-detect pin pass through a synchroniser before any logic uses them.

Top module: `async_rx_brk`

## Requirements
- R1: During and after reset, `ch_wr`, `brk_active`, `ch_par_err`, `ch_frm_err` and `dcd_status` are 0, and `ch_data` is all zeros.
- R2: The receive clock is set by `cfg_factor`: 0 gives 1x, 1 gives 16x, 2 gives 32x and 3 gives 64x the bit rate. In the three oversampled modes, each data, parity and stop bit is sampled one bit period after the previous sample, starting from the start-bit check.
- R3: In 1x mode the first low sample is taken as the start bit. No centring is done, and each later clock takes the next bit.
- R4: In the oversampled modes, a falling edge is checked again half a bit period later. If the line is high at that point, the edge is dropped as noise and no strobe follows.
- R5: `cfg_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first and land in `ch_data` from bit 0 upward, and the bits above the character are 0.
- R6: When parity is on and the data length is below 8, the received parity bit is written to `ch_data` at the bit position equal to the data length. With 8 data bits, `ch_data` holds only the data.
- R7: With parity enabled, `ch_par_err` is set when the count of ones over the data bits and the parity bit is odd (`cfg_par_odd`=0) or even (`cfg_par_odd`=1). With parity disabled it is 0.
- R8: Each completed character gives exactly one single-cycle `ch_wr` pulse. `ch_frm_err` on that pulse is 1 when the sampled stop bit was low.
- R9: A character whose data bits are all zero and whose stop bit is low is not written out. Instead, `brk_active` goes to 1 and stays at 1 while the line stays low.
- R10: When the line returns high after a break, `brk_active` clears. In the same cycle exactly one character is written, with data 0 and `ch_frm_err` 0, and with `ch_par_err` equal to 1 only when parity is enabled with odd sense.
- R11: When `cfg_auto_en`=1 and `dcd_n` is high, the receiver is held idle: a character in progress is dropped and no strobe is issued. When `dcd_n` is low, or when `cfg_auto_en`=0, `dcd_n` has no effect on reception.
- R12: `dcd_status` equals the inverse of `dcd_n` and follows it after exactly SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial data in, idle high |
| dcd_n | input | 1 | Active-low carrier detect |
| cfg_factor | input | 2 | Clock factor select |
| cfg_len | input | LEN_W | Data length select |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_auto_en | input | 1 | Carrier detect gates the receiver |
| ch_data | output | DATA_W | Received character, with the parity bit when it fits |
| ch_par_err | output | 1 | Parity error for this character |
| ch_frm_err | output | 1 | Framing error for this character |
| ch_wr | output | 1 | One-cycle write strobe |
| brk_active | output | 1 | Break in progress |
| dcd_status | output | 1 | Synchronised carrier present |

## Verification
The bench builds the block with its default parameters: 8-bit characters, a 2-bit length field, counters sized for 64x, and a two-stage synchroniser. This is small enough that in 1x mode every data value of every length is sent under no parity, even parity and odd parity. The three oversampled factors get a fixed set of patterns for each length and parity setting, some of them with a deliberately wrong parity bit. Short glitches, missing stop bits, breaks under several parity and clock settings, and carrier gating (including a character cut off part way) are each driven at the pins. Every expected value is computed from the bits as they were sent.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

   typedef enum logic [1:0] {
      CF_X1  = 2'd0,
      CF_X16 = 2'd1,
      CF_X32 = 2'd2,
      CF_X64 = 2'd3
   } clk_factor_e;

endpackage

// File: rtl/rxb_in_sync.sv
module rxb_in_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("rxb_in_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RST_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rxb_frame_fsm.sv
module rxb_frame_fsm
   import rxb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LEN_W      = 2,
   parameter int MAX_FACTOR = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  logic              enable,
   input  logic [1:0]        cfg_factor,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_par_en,
   input  logic              is_break,
   output logic              done,
   output logic [DATA_W-1:0] f_data,
   output logic              f_par,
   output logic              f_stop,
   output logic              brk_end
);

   localparam int CNT_W    = $clog2(MAX_FACTOR) + 1;
   localparam int IDX_W    = $clog2(DATA_W);
   localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;

   generate
      if (MAX_FACTOR < 64) begin : g_bad_factor
         $error("rxb_frame_fsm: MAX_FACTOR must cover 64x");
      end
      if (MIN_BITS < 1) begin : g_bad_len
         $error("rxb_frame_fsm: LEN_W too wide for DATA_W");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] tpb_of(input logic [1:0] f);
      case (f)
         CF_X1:   return CNT_W'(1);
         CF_X16:  return CNT_W'(16);
         CF_X32:  return CNT_W'(32);
         default: return CNT_W'(64);
      endcase
   endfunction

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  tpb;
   logic [CNT_W-1:0]  half;
   logic              hit;
   logic [IDX_W-1:0]  last_idx;

   assign tpb      = tpb_of(cfg_factor);
   assign half     = tpb >> 1;
   assign hit      = (cnt == tpb);
   assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);

   assign done    = enable && (state == RX_STOP) && hit;
   assign f_stop  = line;
   assign brk_end = enable && (state == RX_BREAK) && line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         cnt    <= '0;
         idx    <= '0;
         f_data <= '0;
         f_par  <= 1'b0;
      end else if (!enable) begin
         state <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
      end else begin
         case (state)
            RX_IDLE: begin
               if (!line) begin
                  f_data <= '0;
                  f_par  <= 1'b0;
                  idx    <= '0;
                  cnt    <= CNT_W'(1);
                  state  <= (tpb == CNT_W'(1)) ? RX_DATA : RX_START;
               end
            end
            RX_START: begin
               if (cnt == half) begin
                  cnt   <= CNT_W'(1);
                  state <= line ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_DATA: begin
               if (hit) begin
                  f_data[idx] <= line;
                  cnt         <= CNT_W'(1);
                  if (idx == last_idx) begin
                     idx   <= '0;
                     state <= cfg_par_en ? RX_PAR : RX_STOP;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_PAR: begin
               if (hit) begin
                  f_par <= line;
                  cnt   <= CNT_W'(1);
                  state <= RX_STOP;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_STOP: begin
               if (hit) begin
                  cnt   <= '0;
                  state <= is_break ? RX_BREAK : RX_IDLE;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_BREAK: begin
               cnt <= '0;
               if (line) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R3: in 1x mode a low line in idle goes straight to data bits
   a_r3_x1_no_centring: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && enable && !line && cfg_factor == CF_X1)
      |=> (state == RX_DATA));

   // R9: the break state is held while the line stays low
   a_r9_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_BREAK && enable && !line) |=> (state == RX_BREAK));

endmodule

// File: rtl/rxb_out_stage.sv
module rxb_out_stage #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] f_data,
   input  logic              f_par,
   input  logic              f_stop,
   input  logic              brk_end,
   input  logic              abort,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   output logic              is_break,
   output logic [DATA_W-1:0] ch_data,
   output logic              ch_par_err,
   output logic              ch_frm_err,
   output logic              ch_wr,
   output logic              brk_active
);

   localparam int IDX_W    = $clog2(DATA_W);
   localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;
   localparam logic [IDX_W:0] FULL = (IDX_W + 1)'(DATA_W);

   logic [IDX_W:0]    len_bits;
   logic              par_fits;
   logic [DATA_W-1:0] merged;
   logic              ones_odd;
   logic              par_err;
   logic [IDX_W:0]    stored_bits;

   assign len_bits = (IDX_W + 1)'(MIN_BITS) + (IDX_W + 1)'(cfg_len);
   assign par_fits = cfg_par_en && (len_bits < FULL);
   assign merged   = f_data | (par_fits ? (DATA_W'(f_par) << len_bits) : '0);
   assign ones_odd = (^f_data) ^ (cfg_par_en & f_par);
   assign par_err  = cfg_par_en & (ones_odd ^ cfg_par_odd);
   assign is_break = done && !f_stop && (f_data == '0);
   assign stored_bits = len_bits + (IDX_W + 1)'(par_fits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_wr      <= 1'b0;
         ch_data    <= '0;
         ch_par_err <= 1'b0;
         ch_frm_err <= 1'b0;
         brk_active <= 1'b0;
      end else begin
         ch_wr <= 1'b0;
         if (abort) begin
            brk_active <= 1'b0;
         end else if (done && !is_break) begin
            ch_wr      <= 1'b1;
            ch_data    <= merged;
            ch_par_err <= par_err;
            ch_frm_err <= !f_stop;
         end else if (is_break) begin
            brk_active <= 1'b1;
         end else if (brk_end) begin
            ch_wr      <= 1'b1;
            ch_data    <= '0;
            ch_par_err <= cfg_par_en & cfg_par_odd;
            ch_frm_err <= 1'b0;
            brk_active <= 1'b0;
         end
      end
   end

   // R8: the write strobe never lasts more than one cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wr |=> !ch_wr);

   // R9: entering break writes nothing
   a_r9_no_write_on_break: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_active) |-> !ch_wr);

   // R10: a break that ends without abort writes one clean null
   a_r10_null_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(brk_active) && !$past(abort))
      |-> (ch_wr && ch_data == '0 && !ch_frm_err));

   // R5: nothing above the character (and parity slot) is set
   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wr |-> ((ch_data >> stored_bits) == '0));

endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
   parameter int DATA_W      = 8,
   parameter int LEN_W       = 2,
   parameter int MAX_FACTOR  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              dcd_n,
   input  logic [1:0]        cfg_factor,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_auto_en,
   output logic [DATA_W-1:0] ch_data,
   output logic              ch_par_err,
   output logic              ch_frm_err,
   output logic              ch_wr,
   output logic              brk_active,
   output logic              dcd_status
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("async_rx_brk: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("async_rx_brk: DATA_W too small");
      end
   endgenerate

   logic              line_s;
   logic              dcd_n_s;
   logic              enable;
   logic              done;
   logic [DATA_W-1:0] f_data;
   logic              f_par;
   logic              f_stop;
   logic              brk_end;
   logic              is_break;

   rxb_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (line_s)
   );

   rxb_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dcd (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dcd_n),
      .q     (dcd_n_s)
   );

   assign enable     = !cfg_auto_en || !dcd_n_s;
   assign dcd_status = !dcd_n_s;

   rxb_frame_fsm #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .MAX_FACTOR (MAX_FACTOR)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line       (line_s),
      .enable     (enable),
      .cfg_factor (cfg_factor),
      .cfg_len    (cfg_len),
      .cfg_par_en (cfg_par_en),
      .is_break   (is_break),
      .done       (done),
      .f_data     (f_data),
      .f_par      (f_par),
      .f_stop     (f_stop),
      .brk_end    (brk_end)
   );

   rxb_out_stage #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .f_data      (f_data),
      .f_par       (f_par),
      .f_stop      (f_stop),
      .brk_end     (brk_end),
      .abort       (!enable),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .is_break    (is_break),
      .ch_data     (ch_data),
      .ch_par_err  (ch_par_err),
      .ch_frm_err  (ch_frm_err),
      .ch_wr       (ch_wr),
      .brk_active  (brk_active)
   );

   // R11: a gated receiver issues no strobe on the following cycle
   a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_en && dcd_n_s) |=> !ch_wr);

   // R11: a gated receiver leaves no break pending
   a_r11_break_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_en && dcd_n_s) |=> !brk_active);

endmodule

// File: tb/async_rx_brk_tb_top.sv
`timescale 1ns/1ps
module async_rx_brk_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_line;
   logic       dcd_n;
   logic [1:0] cfg_factor;
   logic [1:0] cfg_len;
   logic       cfg_par_en;
   logic       cfg_par_odd;
   logic       cfg_auto_en;
   logic [7:0] ch_data;
   logic       ch_par_err;
   logic       ch_frm_err;
   logic       ch_wr;
   logic       brk_active;
   logic       dcd_status;

   int n_chk  = 0;
   int n_fail = 0;
   int cap_n  = 0;
   logic [7:0] cap_data;
   logic       cap_perr;
   logic       cap_ferr;
   bit         finished = 1'b0;

   always #2.5 clk = ~clk;

   async_rx_brk dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_line     (rx_line),
      .dcd_n       (dcd_n),
      .cfg_factor  (cfg_factor),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .cfg_auto_en (cfg_auto_en),
      .ch_data     (ch_data),
      .ch_par_err  (ch_par_err),
      .ch_frm_err  (ch_frm_err),
      .ch_wr       (ch_wr),
      .brk_active  (brk_active),
      .dcd_status  (dcd_status)
   );

   always @(negedge clk) begin
      if (rst_n && ch_wr) begin
         cap_n    = cap_n + 1;
         cap_data = ch_data;
         cap_perr = ch_par_err;
         cap_ferr = ch_frm_err;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int tpb(input logic [1:0] f);
      case (f)
         2'd0:    return 1;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return 64;
      endcase
   endfunction

   task automatic drive(input logic v, input int k);
      rx_line = v;
      repeat (k) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input int nb, input bit pe,
                            input logic pv, input bit stop_bad);
      int n;
      n = tpb(cfg_factor);
      drive(1'b0, n);
      for (int i = 0; i < nb; i++) drive(d[i], n);
      if (pe) drive(pv, n);
      if (stop_bad) drive(1'b0, (n == 1) ? 1 : n / 2 + 2);
      else          drive(1'b1, n);
      drive(1'b1, n + 8);
   endtask

   // sends one character and checks the single captured result
   task automatic run_case(input logic [7:0] d, input bit bad_par,
                           input bit stop_bad, input string tag);
      int         nb;
      int         c0;
      logic [7:0] dm;
      logic       pv;
      logic [7:0] exp_d;
      logic       exp_pe;
      nb = 5 + int'(cfg_len);
      dm = d & 8'((1 << nb) - 1);
      pv = cfg_par_odd ? ~(^dm) : (^dm);
      if (bad_par) pv = ~pv;
      exp_d  = dm;
      if (cfg_par_en && nb < 8) exp_d = exp_d | 8'(int'(pv) << nb);
      exp_pe = cfg_par_en && bad_par;
      c0 = cap_n;
      send_char(dm, nb, cfg_par_en, pv, stop_bad);
      chk(cap_n == c0 + 1 && cap_data == exp_d && cap_perr == exp_pe
          && cap_ferr == stop_bad, tag,
          {cap_n - c0 == 1 ? 8'h1 : 8'h0, 6'd0, cap_perr, cap_ferr, 8'd0, cap_data},
          {8'h1, 6'd0, exp_pe, stop_bad, 8'd0, exp_d});
   endtask

   task automatic run_break(input logic [1:0] f, input bit pe, input bit odd);
      int n;
      int c0;
      logic exp_pe;
      cfg_factor = f; cfg_len = 2'd3; cfg_par_en = pe; cfg_par_odd = odd;
      n = tpb(f);
      c0 = cap_n;
      drive(1'b0, (pe ? 11 : 10) * n + 3 * n + 6);
      // R9: break flagged, nothing written
      chk(brk_active == 1'b1 && cap_n == c0, "R9 break entry",
          {brk_active, 8'(cap_n - c0)}, {1'b1, 8'd0});
      drive(1'b1, 6);
      exp_pe = pe && odd;
      // R10: break cleared, one null written
      chk(brk_active == 1'b0 && cap_n == c0 + 1 && cap_data == 8'h00
          && cap_ferr == 1'b0 && cap_perr == exp_pe, "R10 break end null",
          {brk_active, cap_perr, cap_ferr, 8'(cap_n - c0), cap_data},
          {1'b0, exp_pe, 1'b0, 8'd1, 8'h00});
      drive(1'b1, n + 8);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int c0;
      logic [7:0] pats [4];
      pats[0] = 8'h01; pats[1] = 8'hA5; pats[2] = 8'h3C; pats[3] = 8'hFF;

      rst_n = 1'b0; rx_line = 1'b1; dcd_n = 1'b1;
      cfg_factor = 2'd0; cfg_len = 2'd3; cfg_par_en = 1'b0;
      cfg_par_odd = 1'b0; cfg_auto_en = 1'b0;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(ch_wr == 0 && brk_active == 0 && ch_data == 0 && ch_par_err == 0
          && ch_frm_err == 0 && dcd_status == 0, "R1 in reset",
          {ch_wr, brk_active, ch_par_err, ch_frm_err, dcd_status, ch_data}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ch_wr == 0 && brk_active == 0 && ch_data == 0 && dcd_status == 0,
          "R1 after reset", {ch_wr, brk_active, dcd_status, ch_data}, 0);

      // R12: carrier status latency
      dcd_n = 1'b0;
      @(negedge clk);
      chk(dcd_status == 1'b0, "R12 not yet", dcd_status, 0);
      @(negedge clk);
      chk(dcd_status == 1'b1, "R12 after sync", dcd_status, 1);
      dcd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(dcd_status == 1'b0, "R12 released", dcd_status, 0);

      // R2 R3 R5 R6 R7: sweep all factors, lengths and parity settings
      for (int f = 0; f < 4; f++) begin
         for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 3; p++) begin
               cfg_factor  = 2'(f);
               cfg_len     = 2'(l);
               cfg_par_en  = (p != 0);
               cfg_par_odd = (p == 2);
               if (f == 0) begin
                  for (int d = 0; d < (1 << (5 + l)); d++)
                     run_case(8'(d), (p != 0) && (d % 3 == 1), 1'b0,
                              "R3 R5 R6 R7 x1 sweep");
               end else begin
                  for (int k = 0; k < 4; k++)
                     run_case(pats[k], (p != 0) && (k % 2 == 1), 1'b0,
                              "R2 R5 R6 R7 oversampled sweep");
               end
            end
         end
      end

      // R8: missing stop bit on a non-zero character
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      for (int f = 0; f < 4; f++) begin
         cfg_factor = 2'(f);
         run_case(8'h5A, 1'b0, 1'b1, "R8 framing error");
      end
      cfg_factor = 2'd1; cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      run_case(8'h21, 1'b1, 1'b1, "R8 framing with parity");

      // R4: short glitches are rejected, then reception resumes
      cfg_factor = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0;
      c0 = cap_n;
      drive(1'b0, 6);
      drive(1'b1, 60);
      chk(cap_n == c0, "R4 glitch 16x", cap_n - c0, 0);
      cfg_factor = 2'd2;
      c0 = cap_n;
      drive(1'b0, 14);
      drive(1'b1, 100);
      chk(cap_n == c0, "R4 glitch 32x", cap_n - c0, 0);
      run_case(8'hC3, 1'b0, 1'b0, "R4 resume after glitch");

      // R9 R10: breaks under several settings
      run_break(2'd1, 1'b0, 1'b0);
      run_break(2'd0, 1'b1, 1'b1);
      run_break(2'd3, 1'b1, 1'b0);
      run_break(2'd2, 1'b1, 1'b1);

      // R11: carrier gating
      cfg_factor = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
      cfg_auto_en = 1'b1; dcd_n = 1'b0;
      repeat (8) @(negedge clk);
      c0 = cap_n;
      drive(1'b0, 16); drive(1'b1, 16); drive(1'b0, 16);
      dcd_n = 1'b1;
      drive(1'b1, 16); drive(1'b0, 16); drive(1'b1, 16 * 5);
      drive(1'b1, 40);
      dcd_n = 1'b0;
      drive(1'b1, 40);
      chk(cap_n == c0, "R11 aborted character", cap_n - c0, 0);
      dcd_n = 1'b1;
      repeat (8) @(negedge clk);
      c0 = cap_n;
      send_char(8'h96, 8, 1'b0, 1'b0, 1'b0);
      chk(cap_n == c0, "R11 held off", cap_n - c0, 0);
      dcd_n = 1'b0;
      repeat (8) @(negedge clk);
      run_case(8'h96, 1'b0, 1'b0, "R11 carrier present");
      cfg_auto_en = 1'b0; dcd_n = 1'b1;
      repeat (8) @(negedge clk);
      run_case(8'h69, 1'b0, 1'b0, "R11 auto off ignores pin");
      // R11: break in progress is dropped by gating
      cfg_auto_en = 1'b1; dcd_n = 1'b0;
      repeat (8) @(negedge clk);
      c0 = cap_n;
      drive(1'b0, 16 * 13);
      dcd_n = 1'b1;
      drive(1'b0, 8);
      chk(brk_active == 1'b0, "R11 break cleared when gated", brk_active, 0);
      drive(1'b1, 20);
      dcd_n = 1'b0;
      drive(1'b1, 20);
      chk(cap_n == c0, "R11 no null after gated break", cap_n - c0, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule